// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer, after an external dual-modulus prescaler that divides the oscillator by P or P+1. It runs on the prescaler output clock. It uses two down-counters: a 13-bit main count B and a 5-bit swallow count A. It drives the prescaler's modulus-select line, so that each output period holds A prescaler cycles of length P+1 and B−A cycles of length P. The total division from the oscillator is therefore N = B·P + A. Once per period it raises a one-cycle pulse for the phase detector.

A new (A, B) pair is offered with a load strobe. When the divider is idle, a legal pair starts it at once. While it runs, a legal pair is staged and takes over only at the next terminal count, so no period is ever built from a mix of old and new values. A pair with B smaller than A, or with B equal to zero, cannot be realised. Such a pair raises an error flag and holds both counters cleared.

Top module: `pss_divider`

## Requirements
- R1: After the synchronous reset, `mod_hi`, `div_pulse` and `cfg_bad` are low, and the divider stays idle with no pulse until a legal pair is loaded.
- R2: A legal load while idle starts a period on the next edge: `mod_hi` is already high in the first cycle when A is non-zero, and the first `div_pulse` appears in the B-th cycle after the load edge.
- R3: A running divider pulses `div_pulse` for exactly one prescaler-output cycle every B cycles, so the oscillator sees a division of B·P + A.
- R4: In each period, `mod_hi` (1 selects P+1, 0 selects P) is high for the first A cycles and low for the remaining B−A cycles, with no second high stretch.
- R5: With A = 0, `mod_hi` never rises. With A = B, it stays high for the whole period. A = 31, the largest swallow value, is honoured.
- R6: With B = 1, `div_pulse` is high in every cycle, giving a division of P + A.
- R7: A load is legal only when B ≥ 1 and B ≥ A. An illegal load sets `cfg_bad` on the next cycle and clears both counters, and the divider then stays quiet (`mod_hi` and `div_pulse` low) until a legal load arrives.
- R8: A legal load clears `cfg_bad` on the next cycle and restarts the divider from the idle state as in R2.
- R9: A legal load made while running leaves the current period unchanged and takes effect from the period that follows the next terminal count.
- R10: If several legal loads fall in one period, only the last of them is used at the next terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that offers `sw_val` and `main_val` |
| sw_val | input | 5 | Swallow count A |
| main_val | input | 13 | Main count B |
| mod_hi | output | 1 | Modulus select to the prescaler: 1 = P+1, 0 = P |
| div_pulse | output | 1 | One-cycle pulse at the terminal count of the main counter |
| cfg_bad | output | 1 | Last offered pair was illegal; divider held cleared |

## Verification
The properties assume that `load` is a single-cycle strobe that is sampled on the clock, and that `sw_val` and `main_val` are stable whenever it is high. The fall-then-stay-low property for `mod_hi` also takes for granted that a running divider only starts a new period right after its own terminal pulse. The bench keeps to these assumptions. It drives every input on the falling edge of the prescaler clock and holds each load for exactly one cycle. Its mid-period loads are placed well clear of the terminal cycle. The prescaler model samples `mod_hi` only at its own cycle boundary, as a real dual-modulus divider does.

// File: rtl/pss_pkg.sv
package pss_pkg;
    parameter int unsigned SW_W   = 5;
    parameter int unsigned MAIN_W = 13;

    typedef logic [SW_W-1:0]   sw_t;
    typedef logic [MAIN_W-1:0] main_t;

    typedef struct packed {
        main_t main_n;
        sw_t   sw_n;
    } div_cfg_t;

    typedef struct packed {
        logic     running;
        logic     bad;
        div_cfg_t active;
        div_cfg_t pending;
        logic     pend_v;
    } stage_st_t;

    typedef struct packed {
        sw_t   sw_left;
        main_t main_left;
    } count_st_t;
endpackage

// File: rtl/pss_cfg_check.sv
module pss_cfg_check
    import pss_pkg::*;
(
    input  div_cfg_t cfg_i,
    output logic     ok_o
);
    main_t sw_ext;

    always_comb begin
        sw_ext = main_t'(cfg_i.sw_n);
        ok_o   = (cfg_i.main_n != '0) && (cfg_i.main_n >= sw_ext);
    end
endmodule

// File: rtl/pss_cfg_stage.sv
module pss_cfg_stage
    import pss_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  logic     ok_i,
    input  div_cfg_t cfg_i,
    input  logic     term_i,
    output logic     clear_o,
    output logic     reload_o,
    output div_cfg_t reload_cfg_o,
    output logic     bad_o
);
    stage_st_t q, d;
    logic      start;

    always_comb begin
        d            = q;
        start        = load_i && ok_i && !q.running;
        clear_o      = load_i && !ok_i;
        reload_o     = start || (term_i && q.running);
        reload_cfg_o = start ? cfg_i : (q.pend_v ? q.pending : q.active);

        if (clear_o) begin
            d.running = 1'b0;
            d.bad     = 1'b1;
            d.pend_v  = 1'b0;
        end else begin
            if (reload_o) begin
                d.active  = reload_cfg_o;
                d.running = 1'b1;
                d.pend_v  = 1'b0;
            end
            if (load_i && ok_i) begin
                d.bad = 1'b0;
                if (q.running) begin
                    d.pending = cfg_i;
                    d.pend_v  = 1'b1;
                end
            end
        end
        bad_o = q.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pss_count_core.sv
module pss_count_core
    import pss_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear_i,
    input  logic     reload_i,
    input  div_cfg_t cfg_i,
    output logic     mod_hi_o,
    output logic     term_o
);
    count_st_t q, d;

    always_comb begin
        d = q;
        if (clear_i) begin
            d = '0;
        end else if (reload_i) begin
            d.sw_left   = cfg_i.sw_n;
            d.main_left = cfg_i.main_n;
        end else if (q.main_left != '0) begin
            d.main_left = q.main_left - 1'b1;
            if (q.sw_left != '0) d.sw_left = q.sw_left - 1'b1;
        end
        mod_hi_o = (q.sw_left != '0);
        term_o   = (q.main_left == main_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pss_divider.sv
module pss_divider
    import pss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SW_W-1:0]   sw_val,
    input  logic [MAIN_W-1:0] main_val,
    output logic              mod_hi,
    output logic              div_pulse,
    output logic              cfg_bad
);
    div_cfg_t in_cfg;
    div_cfg_t reload_cfg;
    logic     in_ok;
    logic     clear;
    logic     reload;
    logic     term;

    always_comb begin
        in_cfg.sw_n   = sw_val;
        in_cfg.main_n = main_val;
    end

    pss_cfg_check u_check (
        .cfg_i (in_cfg),
        .ok_o  (in_ok)
    );

    pss_cfg_stage u_stage (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .ok_i         (in_ok),
        .cfg_i        (in_cfg),
        .term_i       (term),
        .clear_o      (clear),
        .reload_o     (reload),
        .reload_cfg_o (reload_cfg),
        .bad_o        (cfg_bad)
    );

    pss_count_core u_core (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear),
        .reload_i (reload),
        .cfg_i    (reload_cfg),
        .mod_hi_o (mod_hi),
        .term_o   (term)
    );

    assign div_pulse = term;
endmodule

// File: rtl/pss_divider_chk.sv
module pss_divider_chk
    import pss_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [SW_W-1:0]   sw_val,
    input logic [MAIN_W-1:0] main_val,
    input logic              mod_hi,
    input logic              div_pulse,
    input logic              cfg_bad
);
    logic  legal;
    main_t sw_wide;
    logic  mod_prev_q, dropped_q, dropped_d;

    always_comb begin
        sw_wide = main_t'(sw_val);
        legal   = (main_val != '0) && (sw_wide <= main_val);
        if (div_pulse || load)          dropped_d = 1'b0;
        else if (mod_prev_q && !mod_hi) dropped_d = 1'b1;
        else                            dropped_d = dropped_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_prev_q <= 1'b0;
            dropped_q  <= 1'b0;
        end else begin
            mod_prev_q <= mod_hi;
            dropped_q  <= dropped_d;
        end
    end

    assert_bad_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> (!mod_hi && !div_pulse));

    assert_bad_set_R7: assert property (@(posedge clk) disable iff (rst)
        (load && !legal) |=> (cfg_bad && !div_pulse));

    assert_bad_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (load && legal) |=> !cfg_bad);

    assert_mod_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_hi) |-> ($past(div_pulse) || $past(load)));

    assert_mod_stays_low_R4: assert property (@(posedge clk) disable iff (rst)
        (dropped_q && !div_pulse && !load) |=> !mod_hi);
endmodule

bind pss_divider pss_divider_chk u_chk (.*);

// File: tb/tb_pss_divider.sv
`timescale 1ns/1ps
module tb_pss_divider;
    localparam int PRE_P = 8;

    logic        vco = 1'b0;
    logic        pre_clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [4:0]  sw_val = '0;
    logic [12:0] main_val = '0;
    logic        mod_hi, div_pulse, cfg_bad;
    int          pc = 0;
    longint      vco_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    pss_divider dut (
        .clk(pre_clk), .rst(rst), .load(load), .sw_val(sw_val),
        .main_val(main_val), .mod_hi(mod_hi), .div_pulse(div_pulse),
        .cfg_bad(cfg_bad)
    );

    always #2.5 vco = ~vco;

    // dual-modulus prescaler model: P or P+1 chosen at each output cycle start
    always @(posedge vco) begin
        vco_cnt <= vco_cnt + 1;
        if (pc == 0) begin
            pre_clk <= 1'b1;
            pc <= mod_hi ? PRE_P : PRE_P - 1;
        end else begin
            pc <= pc - 1;
            if (pc == PRE_P / 2) pre_clk <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge pre_clk);
        rst = 1'b1; load = 1'b0;
        repeat (3) @(negedge pre_clk);
        rst = 1'b0;
    endtask

    task automatic drive_load(input int a, input int b);
        sw_val = 5'(a); main_val = 13'(b); load = 1'b1;
    endtask

    // start from idle; returns at the negedge of the first pulse
    task automatic start_run(input int a, input int b, input string req);
        int cnt = 0;
        bit first_mod = 1'b0;
        @(negedge pre_clk);
        drive_load(a, b);
        do begin
            @(negedge pre_clk);
            load = 1'b0;
            cnt++;
            if (cnt == 1) first_mod = mod_hi;
        end while (!div_pulse && cnt < 10000);
        chk(cnt == b, req, "cycles to first pulse", cnt, b);
        chk(first_mod == (a != 0), req, "mod_hi in first cycle", first_mod, a != 0);
    endtask

    // measure one period starting just after a pulse negedge
    task automatic measure(input bit do_ld, input int exp_a, output int cyc,
                           output longint vco_n, output int modc, output int misplaced);
        longint v0 = vco_cnt;
        cyc = 0; modc = 0; misplaced = 0;
        do begin
            @(negedge pre_clk);
            cyc++;
            modc += int'(mod_hi);
            if (mod_hi != (cyc <= exp_a)) misplaced++;
            if (do_ld && cyc == 2) drive_load(1, 3);
            if (do_ld && cyc == 4) drive_load(5, 9);
            if (do_ld && (cyc == 3 || cyc == 5)) load = 1'b0;
        end while (!div_pulse && cyc < 10000);
        vco_n = vco_cnt - v0;
    endtask

    task automatic check_periods(input int a, input int b, input int n, input string req);
        int cyc, modc, mis;
        longint v;
        for (int i = 0; i < n; i++) begin
            measure(1'b0, a, cyc, v, modc, mis);
            chk(cyc == b, req, "cycles per period (R3)", cyc, b);
            chk(v == longint'(b * PRE_P + a), req, "oscillator cycles per period (R3)",
                v, b * PRE_P + a);
            chk(modc == a, req, "mod_hi cycles per period (R4)", modc, a);
            chk(mis == 0, req, "mod_hi misplaced cycles (R4)", mis, 0);
        end
    endtask

    task automatic t_reset();
        int pulses = 0;
        do_reset();
        @(negedge pre_clk);
        chk(!mod_hi && !div_pulse && !cfg_bad, "R1", "outputs after reset",
            {mod_hi, div_pulse, cfg_bad}, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge pre_clk);
            pulses += int'(div_pulse | mod_hi);
        end
        chk(pulses == 0, "R1", "activity while idle", pulses, 0);
    endtask

    task automatic t_basic(input int a, input int b, input string req);
        do_reset();
        start_run(a, b, "R2");
        check_periods(a, b, 2, req);
    endtask

    task automatic t_invalid();
        int act = 0;
        do_reset();
        start_run(3, 10, "R2");
        repeat (3) @(negedge pre_clk);
        drive_load(6, 4);
        @(negedge pre_clk);
        load = 1'b0;
        chk(cfg_bad, "R7", "cfg_bad after B<A", cfg_bad, 1);
        chk(!mod_hi && !div_pulse, "R7", "outputs after B<A", {mod_hi, div_pulse}, 0);
        drive_load(0, 0);
        @(negedge pre_clk);
        load = 1'b0;
        chk(cfg_bad, "R7", "cfg_bad after B=0", cfg_bad, 1);
        for (int i = 0; i < 30; i++) begin
            @(negedge pre_clk);
            act += int'(div_pulse | mod_hi);
        end
        chk(act == 0, "R7", "activity while held", act, 0);
        @(negedge pre_clk);
        drive_load(2, 5);
        @(negedge pre_clk);
        load = 1'b0;
        chk(!cfg_bad, "R8", "cfg_bad after legal load", cfg_bad, 0);
        chk(mod_hi, "R8", "mod_hi at restart", mod_hi, 1);
        repeat (4) @(negedge pre_clk);
        chk(div_pulse, "R8", "first pulse after restart", div_pulse, 1);
        check_periods(2, 5, 1, "R8");
    endtask

    task automatic t_midload();
        int cyc, modc, mis;
        longint v;
        do_reset();
        start_run(2, 6, "R2");
        measure(1'b1, 2, cyc, v, modc, mis);
        chk(cyc == 6, "R9", "period during load cycles", cyc, 6);
        chk(v == 50, "R9", "period during load oscillator cycles", v, 50);
        chk(modc == 2, "R9", "period during load mod_hi cycles", modc, 2);
        measure(1'b0, 5, cyc, v, modc, mis);
        chk(cyc == 9, "R10", "cycles after two loads", cyc, 9);
        chk(v == 77, "R10", "oscillator cycles after two loads", v, 77);
        chk(modc == 5 && mis == 0, "R10", "mod_hi cycles after two loads", modc, 5);
    endtask

    initial begin
        t_reset();
        t_basic(3, 10, "R3");
        t_basic(0, 5, "R5");
        t_basic(7, 7, "R5");
        t_basic(31, 40, "R5");
        t_basic(0, 1, "R6");
        t_basic(1, 1, "R6");
        t_invalid();
        t_midload();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule